// File: doc/BRIEF.md
# Chip-Select Synchronous Serial Receiver

This block receives bytes over a four-wire synchronous serial link. A host reaches it through a small register port. In master mode the block generates the serial clock from the system clock. Each read of the receive data register starts a frame of clocks while receive is enabled, so the first read is a dummy read that starts reception. In slave mode the block takes the clock from a pin and listens only while the active-low chip select is held low.

When a complete frame has been shifted in, MSB first, the byte moves to the data register and a receive-full flag is raised. A host read of the data register lowers that flag. A frame that completes while the flag is still up raises a sticky overrun flag instead. The overrun also freezes the engine until the host writes the flag back to zero. A single interrupt line reports either flag when the interrupt enable is set.

Register map, addressed by `host_addr`:

| Address | Register | Contents |
|---|---|---|
| 0 | Data | Received byte |
| 1 | Status | Bit 0 receive-full, bit 1 overrun |
| 2 | Control | Bit 0 receive enable, bit 1 interrupt enable, bit 2 stop-after-one-frame, bit 3 phase, bit 4 master |
| 3 | Divider | Serial-clock half-period, in system clocks |

Top module: `cs_sync_rx`

## Requirements
- R1: After reset, the status, control and data registers read 0, the divider reads 1, and both `irq` and `sck_out` are low.
- R2: In master mode with receive enabled, a read of the data register (address 0) while idle launches a frame. The frame drives 8 clock pulses on `sck_out`, which idles low. Each pulse has a period of 2×divider system clocks, where the divider is held at address 3. Bits are sampled MSB first.
- R3: When the 8th bit has been sampled and receive-full (status bit 0) is low, the byte is loaded into the data register and receive-full goes to 1.
- R4: `irq` is high exactly when the interrupt enable (control bit 1) is set and either receive-full or overrun (status bit 1) is set.
- R5: A host read of the data register clears receive-full.
- R6: With stop-after-one-frame (control bit 2) set, the master emits exactly 8 pulses and then idles. With it clear, the next frame follows at once.
- R7: A data-register read launches nothing when receive enable (control bit 0) is 0. A read made while receive is enabled launches a new frame.
- R8: If the 8th bit is sampled while receive-full is set, overrun is set, the data register keeps its old byte, and clocking stops. No frame starts and no bit is taken until overrun is cleared.
- R9: Overrun is cleared only by a status write with bit 1 equal to 0. Writing ones to the status register changes nothing, and status writes never change receive-full.
- R10: With phase (control bit 3) at 0, bits are sampled on rising clock edges and receive-full rises together with the 8th rising edge. With phase at 1, bits are sampled on falling edges and receive-full rises one half-period after the 8th rising edge.
- R11: In slave mode (control bit 4 = 0), `sck_in` edges count only while `cs_n` is low. Raising `cs_n` discards a partial frame, and `sck_out` stays low.
- R12: Clearing receive enable aborts a frame in progress and returns `sck_out` low. The data register and both flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request (receive-full or overrun) |
| sck_out | output | 1 | Serial clock generated in master mode |
| sck_in | input | 1 | Serial clock from an external master in slave mode |
| cs_n | input | 1 | Active-low chip select in slave mode |
| sdi | input | 1 | Serial data input |

## Verification
The bench builds the block with an 8-bit frame and a 4-bit divider field. The narrow divider makes the largest half-period, 15, reachable, so the 30-cycle pulse period at the top of the range is measured along with the default working value of 4. A half-period of 4 leaves room for the two-stage input synchronizers between a data change and the sampling edge. It also keeps each frame near 64 cycles, so both clock phases, continuous overrun, abort and slave framing all fit in one short run.

// File: rtl/cs_rx_pkg.sv
package cs_rx_pkg;

    localparam int HOST_W = 8;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_STAT = 2'd1,
        A_CTRL = 2'd2,
        A_DIV  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic master;
        logic phase;
        logic stop_one;
        logic irq_en;
        logic rx_en;
    } ctrl_t;

    typedef struct packed {
        logic ovr;
        logic full;
    } stat_t;

    // True when a clock moving to new_level is the sampling edge for this phase
    function automatic logic samp_edge(input logic phase, input logic new_level);
        return phase ? ~new_level : new_level;
    endfunction

endpackage

// File: rtl/cs_rx_regs.sv
module cs_rx_regs
    import cs_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [1:0]        addr_i,
    input  logic [HOST_W-1:0] wdata_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] done_byte_i,
    output logic [HOST_W-1:0] rdata_o,
    output ctrl_t             ctrl_o,
    output logic [DIV_W-1:0]  half_o,
    output stat_t             stat_o,
    output logic              data_rd_o,
    output logic              irq_o
);
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic [DIV_W-1:0]  half_q;
    logic [DATA_W-1:0] data_q;
    logic              stat_clr;

    assign data_rd_o = rd_i && (reg_addr_e'(addr_i) == A_DATA);
    assign stat_clr  = wr_i && (reg_addr_e'(addr_i) == A_STAT) && !wdata_i[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
            half_q <= DIV_W'(1);
            data_q <= '0;
        end else begin
            if (wr_i && reg_addr_e'(addr_i) == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[4:0]);
            if (wr_i && reg_addr_e'(addr_i) == A_DIV)  half_q <= wdata_i[DIV_W-1:0];
            if (stat_clr)  stat_q.ovr  <= 1'b0;
            if (data_rd_o) stat_q.full <= 1'b0;
            if (done_i) begin
                if (stat_q.full) begin
                    stat_q.ovr <= 1'b1;
                end else begin
                    data_q      <= done_byte_i;
                    stat_q.full <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (reg_addr_e'(addr_i))
            A_DATA:  rdata_o = HOST_W'(data_q);
            A_STAT:  rdata_o = HOST_W'(stat_q);
            A_CTRL:  rdata_o = HOST_W'(ctrl_q);
            default: rdata_o = HOST_W'(half_q);
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign half_o = half_q;
    assign stat_o = stat_q;
    assign irq_o  = ctrl_q.irq_en && (stat_q.full || stat_q.ovr);

    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        (done_i && !stat_q.full) |=> (stat_q.full && data_q == $past(done_byte_i)));
    assert_ovr_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (done_i && stat_q.full) |=> (stat_q.ovr && $stable(data_q)));
    assert_rd_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (data_rd_o && !done_i) |=> !stat_q.full);
    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_q.ovr && !stat_clr) |=> stat_q.ovr);

endmodule

// File: rtl/cs_rx_mclk.sv
module cs_rx_mclk
    import cs_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_i,
    input  logic             ovr_i,
    input  logic             launch_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sck_o,
    output logic             strobe_o,
    output logic             busy_o
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    logic             busy_q, sck_q, tick, last_edge;
    logic [DIV_W-1:0] div_q;
    logic [EW-1:0]    edge_q;
    logic [DIV_W:0]   div_nxt;

    assign div_nxt   = {1'b0, div_q} + (DIV_W+1)'(1);
    assign tick      = busy_q && (div_nxt >= {1'b0, half_i});
    assign last_edge = (edge_q == EW'(EDGES - 1));
    assign strobe_o  = tick && samp_edge(ctrl_i.phase, ~sck_q);

    always_ff @(posedge clk) begin
        if (rst || !ctrl_i.rx_en || !ctrl_i.master || ovr_i) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            div_q  <= '0;
            edge_q <= '0;
        end else if (!busy_q) begin
            div_q  <= '0;
            edge_q <= '0;
            if (launch_i) busy_q <= 1'b1;
        end else if (tick) begin
            div_q <= '0;
            sck_q <= ~sck_q;
            if (last_edge) begin
                edge_q <= '0;
                busy_q <= !ctrl_i.stop_one;
            end else begin
                edge_q <= edge_q + EW'(1);
            end
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign sck_o  = sck_q;
    assign busy_o = busy_q;

    assert_abort_R12: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.rx_en |=> (!busy_q && !sck_q));
    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        ovr_i |=> !busy_q);

endmodule

// File: rtl/cs_rx_shift.sv
module cs_rx_shift
    import cs_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_i,
    input  logic              ovr_i,
    input  logic              m_busy_i,
    input  logic              m_strobe_i,
    input  logic              sck_in,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              done_o,
    output logic [DATA_W-1:0] byte_o
);
    localparam int CW = $clog2(DATA_W);

    logic [2:0]        sync1_q, sync2_q;
    logic              sck_s, cs_s, sdi_s, sck_d;
    logic              s_strobe, strobe, clr;
    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 3'b010;
            sync2_q <= 3'b010;
            sck_d   <= 1'b0;
        end else begin
            sync1_q <= {sck_in, cs_n, sdi};
            sync2_q <= sync1_q;
            sck_d   <= sck_s;
        end
    end

    assign {sck_s, cs_s, sdi_s} = sync2_q;

    assign s_strobe = !ctrl_i.master && !cs_s && (sck_s != sck_d) && samp_edge(ctrl_i.phase, sck_s);
    assign strobe   = ctrl_i.master ? m_strobe_i : s_strobe;
    assign clr      = !ctrl_i.rx_en || ovr_i || (ctrl_i.master ? !m_busy_i : cs_s);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (strobe) begin
            sh_q  <= {sh_q[DATA_W-2:0], sdi_s};
            cnt_q <= (cnt_q == CW'(DATA_W - 1)) ? '0 : cnt_q + CW'(1);
        end
    end

    assign done_o = strobe && !clr && (cnt_q == CW'(DATA_W - 1));
    assign byte_o = {sh_q[DATA_W-2:0], sdi_s};

    assert_cs_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_i.master && cs_s) |=> (cnt_q == '0));

endmodule

// File: rtl/cs_sync_rx.sv
module cs_sync_rx
    import cs_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [1:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        irq,
    output logic        sck_out,
    input  logic        sck_in,
    input  logic        cs_n,
    input  logic        sdi
);
    ctrl_t             ctrl;
    stat_t             stat;
    logic [DIV_W-1:0]  half;
    logic              data_rd, done, m_strobe, m_busy;
    logic [DATA_W-1:0] rx_byte;

    cs_rx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst), .wr_i(host_wr), .rd_i(host_rd), .addr_i(host_addr),
        .wdata_i(host_wdata), .done_i(done), .done_byte_i(rx_byte), .rdata_o(host_rdata),
        .ctrl_o(ctrl), .half_o(half), .stat_o(stat), .data_rd_o(data_rd), .irq_o(irq)
    );

    cs_rx_mclk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_mclk (
        .clk(clk), .rst(rst), .ctrl_i(ctrl), .ovr_i(stat.ovr), .launch_i(data_rd),
        .half_i(half), .sck_o(sck_out), .strobe_o(m_strobe), .busy_o(m_busy)
    );

    cs_rx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .ctrl_i(ctrl), .ovr_i(stat.ovr), .m_busy_i(m_busy),
        .m_strobe_i(m_strobe), .sck_in(sck_in), .cs_n(cs_n), .sdi(sdi),
        .done_o(done), .byte_o(rx_byte)
    );

endmodule

// File: tb/cs_sync_rx_tb.sv
module cs_sync_rx_tb;
    logic clk = 1'b0, rst = 1'b1;
    logic wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic irq, sck_out;
    logic sck_in = 1'b0, cs_n = 1'b1, sdi;
    logic slv = 1'b0, s_sdi = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    // master-side data source model
    logic [7:0] m_byte = 8'h00;
    logic m_ph = 1'b0, prev_sck = 1'b0, irq_d = 1'b0;
    int m_cnt = 0, m_rises = 0, cyc = 0, last_rise = 0, prev_rise = 0, irq_rise = -1;

    localparam logic [8:0] VEC [0:5] = '{9'h0A5, 9'h13C, 9'h0FF, 9'h100, 9'h081, 9'h17E};

    always #2 clk = ~clk;

    assign sdi = slv ? s_sdi : m_byte[3'(7 - m_cnt)];

    cs_sync_rx #(.DATA_W(8), .DIV_W(4)) u_dut (
        .clk(clk), .rst(rst), .host_wr(wr), .host_rd(rd), .host_addr(addr),
        .host_wdata(wdata), .host_rdata(rdata), .irq(irq), .sck_out(sck_out),
        .sck_in(sck_in), .cs_n(cs_n), .sdi(sdi)
    );

    always @(negedge clk) begin
        cyc++;
        if (sck_out !== prev_sck) begin
            if (sck_out) begin
                m_rises++;
                prev_rise = last_rise;
                last_rise = cyc;
            end
            if (sck_out == !m_ph) m_cnt = (m_cnt + 1) % 8;
        end
        prev_sck = sck_out;
        if (irq && !irq_d) irq_rise = cyc;
        irq_d = irq;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input logic [7:0] b, input logic ph);
        m_byte = b; m_ph = ph; m_cnt = 0; m_rises = 0; irq_rise = -1;
    endtask

    task automatic s_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            s_sdi = b[3'(7 - i)];
            waitc(4); sck_in = 1'b1;
            waitc(4); sck_in = 1'b0;
            waitc(4);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] ctl;
        waitc(3); rst = 1'b0; waitc(1);
        // R1 reset state
        rreg(1, d); chk("R1 status", d, 0);
        rreg(2, d); chk("R1 control", d, 0);
        rreg(3, d); chk("R1 divider", d, 1);
        rreg(0, d); chk("R1 data", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 sck", sck_out, 0);

        wreg(3, 8'd4);
        // R7: no launch while receive disabled
        arm(8'h00, 1'b0);
        wreg(2, 8'h14);
        rreg(0, d); waitc(40);
        chk("R7 no clocks when disabled", m_rises, 0);

        // vector table: bit 8 phase, bits 7:0 byte
        for (int v = 0; v < 6; v++) begin
            ctl = 8'h17 | (8'(VEC[v][8]) << 3);
            arm(VEC[v][7:0], VEC[v][8]);
            wreg(2, ctl);
            rreg(0, d);                       // dummy read launches the frame (R2)
            waitc(90);
            chk("R6 pulses per frame", m_rises, 8);
            chk("R2 period", last_rise - prev_rise, 8);
            chk("R6 idle low", sck_out, 0);
            rreg(1, d); chk("R3 full set", d, 1);
            chk("R4 irq on full", irq, 1);
            chk("R10 full timing", irq_rise - last_rise, VEC[v][8] ? 4 : 0);
            wreg(2, ctl & 8'hFE);
            rreg(0, d); chk("R2 data msb first", d, VEC[v][7:0]);
            rreg(1, d); chk("R5 read clears full", d, 0);
            waitc(20);
            chk("R7 read while disabled", m_rises, 8);
        end

        // R4 interrupt enable off, R9 status writes
        arm(8'h3C, 1'b0);
        wreg(2, 8'h15);
        rreg(0, d); waitc(90);
        chk("R4 irq masked", irq, 0);
        wreg(1, 8'h00); rreg(1, d); chk("R9 write 0 keeps full", d, 1);
        wreg(1, 8'hFF); rreg(1, d); chk("R9 write 1 no effect", d, 1);
        wreg(2, 8'h14);
        rreg(0, d); chk("R3 data loaded", d, 8'h3C);

        // R8 continuous mode overrun
        arm(8'h96, 1'b0);
        wreg(2, 8'h13);
        rreg(0, d);
        wait (m_rises == 8);
        @(negedge clk); m_byte = 8'h5A;
        waitc(150);
        chk("R6 continuous pulses", m_rises, 16);
        chk("R8 sck stopped", sck_out, 0);
        rreg(1, d); chk("R8 overrun set", d, 3);
        rreg(0, d); chk("R8 data kept", d, 8'h96);
        waitc(40);
        chk("R8 frozen no launch", m_rises, 16);
        rreg(1, d); chk("R8 overrun stays", d, 2);
        chk("R4 irq on overrun", irq, 1);
        wreg(1, 8'hFF); rreg(1, d); chk("R9 ones ignored", d, 2);
        wreg(1, 8'h00); rreg(1, d); chk("R9 zero clears overrun", d, 0);
        chk("R4 irq low", irq, 0);
        wreg(2, 8'h00);

        // R12 abort mid-frame
        arm(8'hC3, 1'b0);
        wreg(2, 8'h17);
        rreg(0, d); waitc(30);
        wreg(2, 8'h16); waitc(2);
        chk("R12 sck low after abort", sck_out, 0);
        rreg(1, d); chk("R12 flags kept", d, 0);
        rreg(0, d); chk("R12 data kept", d, 8'h96);
        arm(8'h3C, 1'b0);
        wreg(2, 8'h17);
        rreg(0, d); waitc(90);
        wreg(2, 8'h16);
        rreg(0, d); chk("R12 clean restart", d, 8'h3C);

        // R11 slave mode
        slv = 1'b1;
        wreg(2, 8'h03);
        s_bits(8'hFF, 8); waitc(10);
        rreg(1, d); chk("R11 ignored without select", d, 0);
        cs_n = 1'b0; waitc(4);
        s_bits(8'hFF, 3);
        cs_n = 1'b1; waitc(10);
        cs_n = 1'b0; waitc(4);
        s_bits(8'hA5, 8); waitc(10);
        cs_n = 1'b1;
        rreg(1, d); chk("R11 frame received", d, 1);
        rreg(0, d); chk("R11 partial discarded", d, 8'hA5);
        chk("R11 sck_out low", sck_out, 0);
        wreg(2, 8'h0B);
        cs_n = 1'b0; waitc(4);
        s_bits(8'h5E, 8); waitc(10);
        cs_n = 1'b1;
        rreg(0, d); chk("R10 slave falling edge", d, 8'h5E);
        slv = 1'b0;

        // R2 largest divider
        wreg(3, 8'd15);
        arm(8'h69, 1'b0);
        wreg(2, 8'h17);
        rreg(0, d); waitc(300);
        chk("R2 max period", last_rise - prev_rise, 30);
        chk("R6 pulses max div", m_rises, 8);
        wreg(2, 8'h16);
        rreg(0, d); chk("R2 data max div", d, 8'h69);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule